// File: doc/BRIEF.md
# Reaction Timer with Best-Time Memory

This block measures how quickly a person responds to a visual cue. One push-button input serves as both start and stop. A press while the timer is idle, or while it shows a finished result, starts a trial. The block then waits a pseudo-random number of millisecond ticks. After that wait it starts a four-digit decimal counter and flashes three indicator outputs. A second press freezes the counter. The frozen value is compared with a stored best time, and it replaces the best time when it is strictly smaller.

The millisecond tick comes from a prescaler that runs on the system clock. The button input is synchronised and edge-detected inside the block. A level input chooses which value drives the digit outputs: the current time or the best time. While this input is high, the trial is abandoned and the current time is cleared. The best time survives everything except the global reset.

Top module: `reaction_timer`

## Requirements
- R1: A tick pulse occurs once every 2*HALF_DIV system clocks, and both the wait countdown and the decimal counter advance only on ticks.
- R2: A press in the idle or result state clears the current time and starts a wait of DELAY_MIN to DELAY_MIN+DELAY_SPAN-1 ticks. The wait length comes from a free-running 16-bit maximal-length LFSR.
- R3: A press during the wait has no effect. The wait ends at its own time and the display stays at zero.
- R4: While counting, the lowest digit advances on every tick and a carry passes upward on a 9-to-0 wrap. The digit outputs carry four packed BCD digits: digit 0 in bits 3:0, up to digit 3 in bits 15:12, each in the range 0 to 9.
- R5: The count saturates at 9999 and does not wrap.
- R6: When counting starts, all three flash outputs go to 111. They toggle between 111 and 000 every FLASH_HALF ticks, and they are 000 in every other state.
- R7: A press during counting freezes the displayed time, and it stays frozen until the next trial or view change.
- R8: The best time resets to 9999 and is replaced only by a strictly smaller stopped time.
- R9: While view_best_i is high, the digits show the best time (one cycle after it rises), the controller is held idle and the current time is cleared. The best time is kept.
- R10: After reset the digits read 0 and the flash outputs read 000.
- R11: Each press produces exactly one event however long it is held, so a long stop press does not restart the trial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| btn_i | input | 1 | Start/stop push-button, asynchronous level |
| view_best_i | input | 1 | Show best time; also aborts the trial |
| digits_o | output | 4*DIGITS | Packed BCD display value, registered |
| flash_o | output | 3 | Indicator lamps, registered |

## Verification
Saturation at 9999 is the hardest case to reach, because it needs ten thousand ticks without a stop press. The bench shortens the tick with a small prescaler parameter and then simply waits. The random wait length cannot be predicted from the ports. The bench therefore measures the time from each press to the first flash and checks it against the allowed window, rather than checking an exact value. Stop timing is phase-uncertain by a few ticks, so each stopped value is taken as the reference for the best-time comparisons that follow.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COUNT = 2'd2,
    ST_HOLD  = 2'd3
  } rt_state_t;
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int HALF_DIV = 25000
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          slow_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        slow_q <= ~slow_q;
        tick_o <= ~slow_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rt_button_edge.sv
module rt_button_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic btn_i,
  output logic press_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sync_q <= '0;
    else       sync_q <= {sync_q[1:0], btn_i};
  end

  assign press_o = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/rt_lfsr.sv
module rt_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    TAPS = 16'hB400,
  parameter logic [W-1:0]    SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  output logic [W-1:0] value_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) value_o <= SEED;
    else       value_o <= {1'b0, value_o[W-1:1]} ^ (value_o[0] ? TAPS : '0);
  end
endmodule

// File: rtl/rt_bcd_counter.sv
module rt_bcd_counter #(
  parameter int DIGITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [4*DIGITS-1:0]   value_o
);
  logic [DIGITS:0] carry;
  logic            sat;

  assign carry[0] = inc_i & ~sat;

  always_comb begin
    sat = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (value_o[4*i +: 4] != 4'd9) sat = 1'b0;
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] dig_q;
    assign carry[g+1]     = carry[g] & (dig_q == 4'd9);
    assign value_o[4*g +: 4] = dig_q;
    always_ff @(posedge clk_i) begin
      if (rst_i || clr_i)  dig_q <= 4'd0;
      else if (carry[g])   dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
    end
  end
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
  import rt_pkg::*;
#(
  parameter int HALF_DIV   = 25000,
  parameter int DIGITS     = 4,
  parameter int DELAY_MIN  = 1000,
  parameter int DELAY_SPAN = 4000,
  parameter int FLASH_HALF = 250,
  parameter int LFSR_W     = 16
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                btn_i,
  input  logic                view_best_i,
  output logic [4*DIGITS-1:0] digits_o,
  output logic [2:0]          flash_o
);
  localparam int DW  = $clog2(DELAY_MIN + DELAY_SPAN + 1);
  localparam int SB  = $clog2(DELAY_SPAN);
  localparam int FW  = (FLASH_HALF > 1) ? $clog2(FLASH_HALF) : 1;
  localparam logic [4*DIGITS-1:0] ALL9 = {DIGITS{4'd9}};
  localparam logic [FW-1:0]       FLAST = FW'(FLASH_HALF - 1);

  logic                tick, press;
  logic [LFSR_W-1:0]   rnd;
  logic [4*DIGITS-1:0] cur;
  rt_state_t           st_q;
  logic [DW-1:0]       down_q;
  logic [4*DIGITS-1:0] best_q;
  logic                flash_q;
  logic [FW-1:0]       fcnt_q;
  logic [SB-1:0]       low;
  logic [DW-1:0]       delay_val;
  logic                start, stop, bcd_clr, bcd_inc;

  rt_prescaler #(.HALF_DIV(HALF_DIV)) u_pre (
    .clk_i(clk_i), .rst_i(rst_i), .tick_o(tick));

  rt_button_edge u_btn (
    .clk_i(clk_i), .rst_i(rst_i), .btn_i(btn_i), .press_o(press));

  rt_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk_i(clk_i), .rst_i(rst_i), .value_o(rnd));

  rt_bcd_counter #(.DIGITS(DIGITS)) u_bcd (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(bcd_clr), .inc_i(bcd_inc), .value_o(cur));

  // Fold the random low bits into the span, then offset by the minimum.
  always_comb begin
    low = rnd[SB-1:0];
    if (SB'(DELAY_SPAN) <= low) low = low - SB'(DELAY_SPAN);
    delay_val = DW'(DELAY_MIN) + DW'(low);
  end

  assign start   = press & ~view_best_i & ((st_q == ST_IDLE) | (st_q == ST_HOLD));
  assign stop    = press & ~view_best_i & (st_q == ST_COUNT);
  assign bcd_clr = view_best_i | start;
  assign bcd_inc = (st_q == ST_COUNT) & tick & ~press & ~view_best_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q    <= ST_IDLE;
      down_q  <= '0;
      best_q  <= ALL9;
      flash_q <= 1'b0;
      fcnt_q  <= '0;
    end else if (view_best_i) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE, ST_HOLD: if (start) begin
          st_q   <= ST_WAIT;
          down_q <= delay_val;
        end
        ST_WAIT: if (tick) begin
          if (down_q == DW'(1)) begin
            st_q    <= ST_COUNT;
            flash_q <= 1'b1;
            fcnt_q  <= '0;
          end
          down_q <= down_q - 1'b1;
        end
        ST_COUNT: begin
          if (stop) begin
            st_q <= ST_HOLD;
            if (cur < best_q) best_q <= cur;
          end else if (tick) begin
            if (fcnt_q == FLAST) begin
              fcnt_q  <= '0;
              flash_q <= ~flash_q;
            end else begin
              fcnt_q <= fcnt_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      digits_o <= '0;
      flash_o  <= 3'b000;
    end else begin
      digits_o <= view_best_i ? best_q : cur;
      flash_o  <= (st_q == ST_COUNT) ? {3{flash_q}} : 3'b000;
    end
  end
endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import rt_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                press,
  input logic                tick,
  input logic                view_best_i,
  input rt_state_t           st_q,
  input logic [4*DIGITS-1:0] cur,
  input logic [4*DIGITS-1:0] best_q,
  input logic [4*DIGITS-1:0] digits_o,
  input logic [2:0]          flash_o
);
  localparam logic [4*DIGITS-1:0] ALL9 = {DIGITS{4'd9}};

  for (genvar g = 0; g < DIGITS; g++) begin : g_bcd
    p_digit_valid_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      digits_o[4*g +: 4] <= 4'd9);
  end

  p_saturate_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == ST_COUNT && cur == ALL9 && !view_best_i) |=> (cur == ALL9));

  p_wait_press_ignored_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == ST_WAIT && press && !tick && !view_best_i) |=> (st_q == ST_WAIT));

  p_flash_only_counting_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (flash_o != 3'b000) |-> ($past(st_q) == ST_COUNT));

  p_best_never_rises_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (best_q <= $past(best_q)));

  p_view_forces_idle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    view_best_i |=> (st_q == ST_IDLE && cur == '0));
endmodule

bind reaction_timer rt_checker #(.DIGITS(DIGITS)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .press(press), .tick(tick),
  .view_best_i(view_best_i), .st_q(st_q), .cur(cur), .best_q(best_q),
  .digits_o(digits_o), .flash_o(flash_o));

// File: tb/reaction_timer_test.sv
module reaction_timer_test;
  localparam int HALF_DIV   = 2;
  localparam int TICKC      = 2 * HALF_DIV;
  localparam int DELAY_MIN  = 100;
  localparam int DELAY_SPAN = 400;
  localparam int FLASH_HALF = 50;
  localparam int NV         = 4;
  localparam int REACT [NV] = '{400, 800, 200, 600};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        btn = 1'b0;
  logic        view = 1'b0;
  logic [15:0] digits;
  logic [2:0]  flash;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  reaction_timer #(.HALF_DIV(HALF_DIV), .DIGITS(4), .DELAY_MIN(DELAY_MIN),
                   .DELAY_SPAN(DELAY_SPAN), .FLASH_HALF(FLASH_HALF)) uut (
    .clk_i(clk), .rst_i(rst), .btn_i(btn), .view_best_i(view),
    .digits_o(digits), .flash_o(flash));

  function automatic int bcd2int(input logic [15:0] v);
    return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input int hold);
    @(negedge clk); btn = 1'b1;
    wait_cyc(hold);
    btn = 1'b0;
  endtask

  // Cycles from start of a press until flash turns on.
  task automatic wait_flash(output int n);
    n = 0;
    while (flash == 3'b000 && n < 30000) begin
      @(negedge clk); n++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n, exp_best, got, lo, hi;
    logic [15:0] held;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    check(digits == 16'h0000, "R10 digits", digits, 0);
    check(flash == 3'b000, "R10 flash", flash, 0);
    view = 1'b1; wait_cyc(2);
    check(digits == 16'h9999, "R8 best reset", bcd2int(digits), 9999);
    view = 1'b0; wait_cyc(2);

    exp_best = 9999;
    lo = DELAY_MIN * TICKC - 8;
    hi = (DELAY_MIN + DELAY_SPAN - 1) * TICKC + 12;
    for (int v = 0; v < NV; v++) begin
      push(3);
      wait_flash(n);
      n += 3;
      check(n >= lo && n <= hi, "R2 wait window", n, lo);
      check(flash == 3'b111, "R6 flash on", flash, 7);
      if (REACT[v] >= 500) begin
        wait_cyc(240);
        check(flash == 3'b000, "R6 flash toggle off", flash, 0);
        wait_cyc(200);
        check(flash == 3'b111, "R6 flash toggle on", flash, 7);
        wait_cyc(REACT[v] - 440);
      end else begin
        wait_cyc(REACT[v]);
      end
      push(3);
      wait_cyc(8);
      got = bcd2int(digits);
      // R1/R4: ticks every TICKC cycles counted in BCD
      check(got >= REACT[v]/TICKC - 2 && got <= REACT[v]/TICKC + 3, "R4 count", got, REACT[v]/TICKC);
      check(flash == 3'b000, "R6 flash off in hold", flash, 0);
      held = digits;
      wait_cyc(100);
      check(digits == held, "R7 frozen", bcd2int(digits), bcd2int(held));
      if (got < exp_best) exp_best = got;
      view = 1'b1; wait_cyc(2);
      check(bcd2int(digits) == exp_best, "R8 best min", bcd2int(digits), exp_best);
      view = 1'b0; wait_cyc(2);
      check(digits == 16'h0000, "R9 current cleared", bcd2int(digits), 0);
    end

    // R3: press during wait is ignored
    push(3);
    wait_cyc(40);
    push(5);
    wait_cyc(10);
    check(digits == 16'h0000 && flash == 3'b000, "R3 wait unchanged", digits, 0);
    wait_flash(n);
    n += 61;
    check(n >= lo && n <= hi, "R3 wait ends on time", n, hi);
    // R11: long stop press gives one event
    wait_cyc(300);
    push(400);
    wait_cyc(8);
    got = bcd2int(digits);
    check(got >= 300/TICKC - 2 && got <= 300/TICKC + 3, "R11 held stop", got, 300/TICKC);
    check(flash == 3'b000, "R11 no restart", flash, 0);
    if (got < exp_best) exp_best = got;
    // R2: restart straight from result state
    push(3);
    wait_cyc(8);
    check(digits == 16'h0000, "R2 restart clears", bcd2int(digits), 0);
    wait_flash(n);
    // R9: view during counting aborts
    wait_cyc(100);
    view = 1'b1; wait_cyc(3);
    check(bcd2int(digits) == exp_best, "R9 view shows best", bcd2int(digits), exp_best);
    check(flash == 3'b000, "R9 flash off", flash, 0);
    view = 1'b0; wait_cyc(300);
    check(digits == 16'h0000 && flash == 3'b000, "R9 idle after view", digits, 0);
    // R5: saturation, best unchanged
    push(3);
    wait_flash(n);
    wait_cyc(10000 * TICKC + 500);
    check(digits == 16'h9999, "R5 saturate", bcd2int(digits), 9999);
    push(3);
    wait_cyc(8);
    check(digits == 16'h9999, "R5 stop at max", bcd2int(digits), 9999);
    view = 1'b1; wait_cyc(2);
    check(bcd2int(digits) == exp_best, "R8 best kept", bcd2int(digits), exp_best);
    view = 1'b0; wait_cyc(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule